// File: doc/BRIEF.md
# DAC Channel Sample Source Selector

This block produces the 16-bit sample for one converter channel. A 4-bit select code chooses where the sample comes from. Two choices are live data paths: samples that a DMA engine streams in, and samples looped back from an ADC. The remaining choices are built-in test sources: a constant zero word, a rising 16-bit ramp, two pseudo-random bit sequences (seven-stage and fifteen-stage), and the bitwise complements of those two sequences. Any code outside this set yields zero.

The converter side pulses a one-cycle sample-request strobe each time it wants a new word. The block registers the chosen word and presents it, together with a one-cycle valid flag, on the clock edge after the request. The built-in generators step forward only on a request, so they stay aligned with the converter update rate. They step on every request, whichever source is selected. The DMA side receives a ready indication only when the DMA source is selected and a request is present. A live source whose valid flag is low at request time yields a zero word.

Top module: `dac_src_sel`

## Requirements
- R1: After reset, `smp_o` is 0x0000, `smp_vld_o` and `dma_ready_o` are low, the ramp value is 0x0000 and both sequence registers hold all ones.
- R2: With select 0x2, a request returns `dma_data_i` when `dma_valid_i` is high, and 0x0000 when it is low.
- R3: `dma_ready_o` is high exactly when `req_i` is high and the select is 0x2, in the same cycle.
- R4: With select 0x8, a request returns `lb_data_i` when `lb_valid_i` is high, and 0x0000 when it is low.
- R5: With select 0x3, a request returns 0x0000.
- R6: With select 0xB, a request returns the ramp value. The ramp increases by one on every request and wraps from 0xFFFF to 0x0000.
- R7: Select 0x6 returns the next 16 bits of the sequence x^7+x^6+1, and select 0x7 returns the next 16 bits of x^15+x^14+1. Each shift register shifts left, and its new LSB is the XOR of its two top stages. The first new bit of a word lands in bit 15.
- R8: Select 0x4 returns the bitwise inverse of the 0x6 word, and select 0x5 returns the bitwise inverse of the 0x7 word.
- R9: The ramp and both sequences advance by one word on every request, whatever the select, and never without a request. Without a request, `smp_o` holds its value.
- R10: Select codes 0x0, 0x1, 0x9, 0xA and 0xC to 0xF return 0x0000.
- R11: `smp_o` and `smp_vld_o` update on the clock edge that samples `req_i`. `smp_vld_o` is high for exactly the cycles that follow a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_i | input | 4 | Source select code |
| req_i | input | 1 | Sample-request strobe from the converter side |
| dma_data_i | input | 16 | Sample word from the DMA stream |
| dma_valid_i | input | 1 | DMA word present |
| dma_ready_o | output | 1 | DMA word consumed this cycle |
| lb_data_i | input | 16 | Loopback sample from the ADC |
| lb_valid_i | input | 1 | Loopback word present |
| smp_o | output | 16 | Registered channel sample |
| smp_vld_o | output | 1 | New sample on `smp_o` |

## Verification
The ramp is swept through more than its full 65536-word period with a request in every cycle, which exposes an off-by-one or a missing wrap. Hundreds of words are compared from each sequence and from each inverted form. These runs are interleaved with idle gaps and with requests made under other selects. That separates a generator that steps on every request from one that steps only while it is selected or steps without a request. The live paths are tried with distinct data words and with valid high and low, while the other source carries conflicting data. Every unsupported code is driven with non-zero live inputs, to show that no data leaks through.

// File: rtl/dac_src_pkg.sv
package dac_src_pkg;

   localparam int SEL_W    = 4;
   localparam int SMP_W    = 16;
   localparam int PNA_LEN  = 7;
   localparam int PNB_LEN  = 15;

   localparam logic [SEL_W-1:0] SRC_DMA    = 4'h2;
   localparam logic [SEL_W-1:0] SRC_ZERO   = 4'h3;
   localparam logic [SEL_W-1:0] SRC_PNA_N  = 4'h4;
   localparam logic [SEL_W-1:0] SRC_PNB_N  = 4'h5;
   localparam logic [SEL_W-1:0] SRC_PNA    = 4'h6;
   localparam logic [SEL_W-1:0] SRC_PNB    = 4'h7;
   localparam logic [SEL_W-1:0] SRC_LOOP   = 4'h8;
   localparam logic [SEL_W-1:0] SRC_RAMP   = 4'hB;

endpackage

// File: rtl/dsel_ramp_gen.sv
module dsel_ramp_gen #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv_i,
   output logic [W-1:0] val_o
);

   generate
      if (W < 2) begin : g_bad_w
         $error("dsel_ramp_gen: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (adv_i) begin
         cnt_q <= cnt_q + {{(W-1){1'b0}}, 1'b1};
      end
   end

   assign val_o = cnt_q;

endmodule

// File: rtl/dsel_prbs_gen.sv
module dsel_prbs_gen #(
   parameter int LEN    = 7,
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv_i,
   output logic [WORD_W-1:0] word_o
);

   generate
      if (LEN < 3) begin : g_bad_len
         $error("dsel_prbs_gen: LEN must be at least 3");
      end
      if (WORD_W < 1) begin : g_bad_word
         $error("dsel_prbs_gen: WORD_W must be at least 1");
      end
   endgenerate

   logic [LEN-1:0]    state_q;
   logic [LEN-1:0]    state_d;
   logic [WORD_W-1:0] word_c;
   logic              fb;

   // Unrolled WORD_W steps of x^LEN + x^(LEN-1) + 1, first bit to MSB
   always_comb begin
      state_d = state_q;
      word_c  = '0;
      fb      = 1'b0;
      for (int i = 0; i < WORD_W; i++) begin
         fb                 = state_d[LEN-1] ^ state_d[LEN-2];
         word_c[WORD_W-1-i] = fb;
         state_d            = {state_d[LEN-2:0], fb};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= '1;
      end else if (adv_i) begin
         state_q <= state_d;
      end
   end

   assign word_o = word_c;

endmodule

// File: rtl/dsel_src_mux.sv
module dsel_src_mux
   import dac_src_pkg::*;
#(
   parameter int W = SMP_W
) (
   input  logic [SEL_W-1:0] sel_i,
   input  logic [W-1:0]     dma_data_i,
   input  logic             dma_valid_i,
   input  logic [W-1:0]     lb_data_i,
   input  logic             lb_valid_i,
   input  logic [W-1:0]     ramp_i,
   input  logic [W-1:0]     pna_i,
   input  logic [W-1:0]     pnb_i,
   output logic [W-1:0]     smp_o
);

   always_comb begin
      case (sel_i)
         SRC_DMA:   smp_o = dma_valid_i ? dma_data_i : '0;
         SRC_LOOP:  smp_o = lb_valid_i ? lb_data_i : '0;
         SRC_ZERO:  smp_o = '0;
         SRC_RAMP:  smp_o = ramp_i;
         SRC_PNA:   smp_o = pna_i;
         SRC_PNB:   smp_o = pnb_i;
         SRC_PNA_N: smp_o = ~pna_i;
         SRC_PNB_N: smp_o = ~pnb_i;
         default:   smp_o = '0;
      endcase
   end

endmodule

// File: rtl/dac_src_sel.sv
module dac_src_sel
   import dac_src_pkg::*;
#(
   parameter int DATA_W = SMP_W,
   parameter int PNA_N  = PNA_LEN,
   parameter int PNB_N  = PNB_LEN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  sel_i,
   input  logic              req_i,
   input  logic [DATA_W-1:0] dma_data_i,
   input  logic              dma_valid_i,
   output logic              dma_ready_o,
   input  logic [DATA_W-1:0] lb_data_i,
   input  logic              lb_valid_i,
   output logic [DATA_W-1:0] smp_o,
   output logic              smp_vld_o
);

   generate
      if (DATA_W < 8) begin : g_bad_data_w
         $error("dac_src_sel: DATA_W must be at least 8");
      end
      if (PNA_N >= PNB_N) begin : g_bad_pn_order
         $error("dac_src_sel: PNA_N must be shorter than PNB_N");
      end
   endgenerate

   logic [DATA_W-1:0] ramp_w;
   logic [DATA_W-1:0] pna_w;
   logic [DATA_W-1:0] pnb_w;
   logic [DATA_W-1:0] mux_w;
   logic [DATA_W-1:0] smp_q;
   logic              vld_q;

   dsel_ramp_gen #(.W(DATA_W)) u_ramp (
      .clk   (clk),
      .rst_n (rst_n),
      .adv_i (req_i),
      .val_o (ramp_w)
   );

   dsel_prbs_gen #(.LEN(PNA_N), .WORD_W(DATA_W)) u_pna (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv_i  (req_i),
      .word_o (pna_w)
   );

   dsel_prbs_gen #(.LEN(PNB_N), .WORD_W(DATA_W)) u_pnb (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv_i  (req_i),
      .word_o (pnb_w)
   );

   dsel_src_mux #(.W(DATA_W)) u_mux (
      .sel_i       (sel_i),
      .dma_data_i  (dma_data_i),
      .dma_valid_i (dma_valid_i),
      .lb_data_i   (lb_data_i),
      .lb_valid_i  (lb_valid_i),
      .ramp_i      (ramp_w),
      .pna_i       (pna_w),
      .pnb_i       (pnb_w),
      .smp_o       (mux_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         smp_q <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= req_i;
         if (req_i) begin
            smp_q <= mux_w;
         end
      end
   end

   assign dma_ready_o = req_i && (sel_i == SRC_DMA);
   assign smp_o       = smp_q;
   assign smp_vld_o   = vld_q;

endmodule

// File: rtl/dac_src_sel_chk.sv
module dac_src_sel_chk
   import dac_src_pkg::*;
#(
   parameter int DATA_W = SMP_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [SEL_W-1:0]  sel_i,
   input logic              req_i,
   input logic [DATA_W-1:0] dma_data_i,
   input logic              dma_valid_i,
   input logic              dma_ready_o,
   input logic [DATA_W-1:0] lb_data_i,
   input logic              lb_valid_i,
   input logic [DATA_W-1:0] smp_o,
   input logic              smp_vld_o
);

   a_r3_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      dma_ready_o |-> req_i);

   a_r3_ready_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
      dma_ready_o |-> (sel_i == SRC_DMA));

   a_r11_vld_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> smp_vld_o);

   a_r11_no_vld_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> !smp_vld_o);

   a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> $stable(smp_o));

   a_r5_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && sel_i == SRC_ZERO) |=> (smp_o == '0));

   a_r2_dma_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && sel_i == SRC_DMA && dma_valid_i) |=> (smp_o == $past(dma_data_i)));

   a_r4_loop_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && sel_i == SRC_LOOP && lb_valid_i) |=> (smp_o == $past(lb_data_i)));

   a_r6_ramp_step: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && sel_i == SRC_RAMP && $past(req_i && sel_i == SRC_RAMP))
      |=> (smp_o == $past(smp_o) + 1'b1));

endmodule

bind dac_src_sel dac_src_sel_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/dac_src_sel_tb_top.sv
module dac_src_sel_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  sel_i = 4'h0;
   logic        req_i = 1'b0;
   logic [15:0] dma_data_i = '0;
   logic        dma_valid_i = 1'b0;
   logic        dma_ready_o;
   logic [15:0] lb_data_i = '0;
   logic        lb_valid_i = 1'b0;
   logic [15:0] smp_o;
   logic        smp_vld_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [15:0] m_ramp = 16'h0000;
   logic [14:0] m_pa   = 15'h7FFF;
   logic [14:0] m_pb   = 15'h7FFF;
   logic [15:0] last_smp = 16'h0000;

   always #5 clk = ~clk;

   dac_src_sel dut_i (
      .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .req_i(req_i),
      .dma_data_i(dma_data_i), .dma_valid_i(dma_valid_i), .dma_ready_o(dma_ready_o),
      .lb_data_i(lb_data_i), .lb_valid_i(lb_valid_i),
      .smp_o(smp_o), .smp_vld_o(smp_vld_o)
   );

   function automatic logic [15:0] pn_word(input logic [14:0] st, input int len);
      logic [15:0] w = '0;
      logic b;
      for (int k = 0; k < 16; k++) begin
         b  = st[len-1] ^ st[len-2];
         w  = {w[14:0], b};
         st = ({st[13:0], 1'b0} | {14'd0, b}) & ((15'h7FFF) >> (15 - len));
      end
      return w;
   endfunction

   function automatic logic [14:0] pn_next(input logic [14:0] st, input int len);
      logic b;
      for (int k = 0; k < 16; k++) begin
         b  = st[len-1] ^ st[len-2];
         st = ({st[13:0], 1'b0} | {14'd0, b}) & ((15'h7FFF) >> (15 - len));
      end
      return st;
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] expect_word(input logic [3:0] s, input logic [15:0] dd,
                                               input logic dv, input logic [15:0] ld, input logic lv);
      case (s)
         4'h2: return dv ? dd : 16'h0;
         4'h8: return lv ? ld : 16'h0;
         4'hB: return m_ramp;
         4'h6: return pn_word(m_pa, 7);
         4'h7: return pn_word(m_pb, 15);
         4'h4: return ~pn_word(m_pa, 7);
         4'h5: return ~pn_word(m_pb, 15);
         default: return 16'h0;
      endcase
   endfunction

   task automatic do_req(input string req, input logic [3:0] s, input logic [15:0] dd,
                         input logic dv, input logic [15:0] ld, input logic lv);
      logic [15:0] exp;
      @(negedge clk);
      sel_i = s; dma_data_i = dd; dma_valid_i = dv; lb_data_i = ld; lb_valid_i = lv; req_i = 1'b1;
      #1;
      chk("R3 ready with request", {15'd0, dma_ready_o}, {15'd0, (s == 4'h2)});
      exp    = expect_word(s, dd, dv, ld, lv);
      m_ramp = m_ramp + 16'd1;
      m_pa   = pn_next(m_pa, 7);
      m_pb   = pn_next(m_pb, 15);
      @(posedge clk);
      #1;
      chk("R11 valid after request", {15'd0, smp_vld_o}, 16'd1);
      chk(req, smp_o, exp);
      last_smp = exp;
   endtask

   task automatic do_idle(input logic [3:0] s);
      @(negedge clk);
      sel_i = s; req_i = 1'b0; dma_valid_i = 1'b1; dma_data_i = 16'hA5A5;
      lb_valid_i = 1'b1; lb_data_i = 16'h5A5A;
      #1;
      chk("R3 no ready without request", {15'd0, dma_ready_o}, 16'd0);
      @(posedge clk);
      #1;
      chk("R9 idle holds sample", smp_o, last_smp);
      chk("R11 no valid when idle", {15'd0, smp_vld_o}, 16'd0);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1 reset sample", smp_o, 16'h0);
      chk("R1 reset valid", {15'd0, smp_vld_o}, 16'd0);
      chk("R1 reset ready", {15'd0, dma_ready_o}, 16'd0);
      @(negedge clk);
      rst_n = 1'b1;
      do_idle(4'h2);
      // R1 first words show the reset seeds
      do_req("R1 R6 ramp starts at zero", 4'hB, 16'h1111, 1'b1, 16'h2222, 1'b1);
      do_req("R1 R7 seven-stage first word", 4'h6, 16'h0, 1'b0, 16'h0, 1'b0);
      do_req("R1 R7 fifteen-stage word", 4'h7, 16'h0, 1'b0, 16'h0, 1'b0);
      // R2 DMA path
      do_req("R2 dma pass", 4'h2, 16'h1234, 1'b1, 16'hFFFF, 1'b1);
      do_req("R2 dma pass", 4'h2, 16'hFFFF, 1'b1, 16'h0000, 1'b0);
      do_req("R2 dma pass", 4'h2, 16'h8001, 1'b1, 16'h7777, 1'b1);
      do_req("R2 dma not valid gives zero", 4'h2, 16'hBEEF, 1'b0, 16'h7777, 1'b1);
      do_idle(4'h2);
      // R4 loopback path
      do_req("R4 loop pass", 4'h8, 16'hCAFE, 1'b1, 16'h4321, 1'b1);
      do_req("R4 loop pass", 4'h8, 16'h0000, 1'b0, 16'hFFFE, 1'b1);
      do_req("R4 loop not valid gives zero", 4'h8, 16'h9999, 1'b1, 16'h4321, 1'b0);
      // R5 zero code
      do_req("R5 zero code", 4'h3, 16'hFFFF, 1'b1, 16'hFFFF, 1'b1);
      // R10 unsupported codes
      for (int c = 0; c < 16; c++) begin
         if (c == 0 || c == 1 || c == 9 || c == 10 || c >= 12)
            do_req("R10 unsupported code gives zero", c[3:0], 16'hFFFF, 1'b1, 16'hFFFF, 1'b1);
      end
      // R7 R8 R9 sequences with gaps and foreign requests
      for (int n = 0; n < 200; n++) begin
         do_req("R7 seven-stage word", 4'h6, 16'h0, 1'b0, 16'h0, 1'b0);
         do_req("R7 fifteen-stage word", 4'h7, 16'h0, 1'b0, 16'h0, 1'b0);
         if (n % 3 == 0) do_idle(4'h6);
         do_req("R8 inverted seven-stage", 4'h4, 16'h0, 1'b0, 16'h0, 1'b0);
         do_req("R8 inverted fifteen-stage", 4'h5, 16'h0, 1'b0, 16'h0, 1'b0);
         if (n % 5 == 0) do_req("R9 advance under other code", 4'h2, n[15:0], 1'b1, 16'h0, 1'b0);
      end
      // R6 ramp sweep through wrap
      for (int n = 0; n < 65540; n++) begin
         do_req("R6 ramp word", 4'hB, 16'h0, 1'b0, 16'h0, 1'b0);
      end
      do_idle(4'hB);
      do_req("R6 ramp after idle", 4'hB, 16'h0, 1'b0, 16'h0, 1'b0);
      @(negedge clk);
      req_i = 1'b0;
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule